// File: doc/BRIEF.md
# Register Spill Engine with Tag Collection

This block moves 64-bit stacked registers out to a backing-store memory. Each register carries a one-bit "not-a-thing" tag. As a register is spilled, its tag is recorded in a 64-bit collection register, at the bit chosen by the word-index field of the store pointer. Every 64th slot of the backing store is reserved. When the store pointer lands on that slot, the engine writes the collection word there in place of a register, and then starts a fresh collection.

A control register holds a mode field and a byte-order bit. A nonzero mode lets the engine spill. A zero mode parks the engine, and it is the only state in which software may read or write the collection register. Any access made in a nonzero mode raises a one-cycle illegal-operation pulse.

The memory side is a single registered store slot with a valid/ready handshake. Software can also reload the store pointer or issue a load-reset. Either one discards the current collection.

Top module: `rspill_engine`

## Requirements
- R1: While `rst_n` is low at a clock edge, the store pointer, the collection register, the mode field and the byte-order bit clear to 0. After that edge `mem_valid`, `nat_illegal` and `spill_ready` are 0.
- R2: `spill_ready` is high only when all of the following hold: the mode field is nonzero, the store slot is empty, pointer bits 8..3 are not 0x3F, and no pointer write or load-reset is present. An accepted spill shows up on the next cycle as `mem_valid`=1 at `mem_addr` equal to the store pointer at the accepting edge.
- R3: A spilled register's tag is written to collection bit `store_ptr[8:3]`. Bit x therefore belongs to the register at address {`store_ptr[63:9]`, x[5:0], 3'b000}. The same spill clears every bit above that index.
- R4: Bit 63 of the collection register always reads as 0. A software write to bit 63 has no effect.
- R5: A software read returns collection bits 0 up to `store_ptr[8:3]`, and every bit above that index reads as 0.
- R6: `nat_rd` or `nat_wr` is legal only while the mode field is 0. A legal read presents the value on `nat_rdata` one cycle later. An access made while the mode is nonzero pulses `nat_illegal` for one cycle and leaves the collection register unchanged.
- R7: With the byte-order bit at 0, `mem_data` equals the register value, so the least significant byte goes to the lowest address. With the bit at 1, the byte order is reversed, so the most significant byte goes to the lowest address. The collection word follows the same rule.
- R8: When `store_ptr[8:3]` = 0x3F and the mode is nonzero, `spill_ready` stays 0 and the engine stores the whole masked collection word at the store pointer. Pending register spills wait for that one store slot.
- R9: The store pointer advances by 8 for every store accepted (`mem_valid` and `mem_ready` both high). While `mem_ready` is low, `mem_valid`, `mem_addr`, `mem_data` and the pointer hold their values.
- R10: A pointer write, a load-reset, or the acceptance of a collection-word store clears the collection register to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Load the mode field and byte-order bit |
| ctl_mode | input | 2 | New mode field; 0 parks the engine |
| ctl_big | input | 1 | New byte-order bit; 1 puts the most significant byte first |
| ptr_wr | input | 1 | Software write of the store pointer |
| ptr_wdata | input | 64 | New store pointer (low 3 bits are dropped) |
| load_reset | input | 1 | Load-reset operation; discards the collection |
| spill_valid | input | 1 | A register is offered for spilling |
| spill_data | input | 64 | Register value to spill |
| spill_tag | input | 1 | Not-a-thing tag of that register |
| spill_ready | output | 1 | Spill accepted at this edge when valid |
| nat_rd | input | 1 | Software read of the collection register |
| nat_wr | input | 1 | Software write of the collection register |
| nat_wdata | input | 64 | Data for a software write |
| nat_rdata | output | 64 | Result of the last legal read |
| nat_illegal | output | 1 | One-cycle pulse for an access in a nonzero mode |
| mem_valid | output | 1 | Store slot holds a store |
| mem_ready | input | 1 | Memory accepts the store this edge |
| mem_addr | output | 64 | Store address |
| mem_data | output | 64 | Store data in the selected byte order |
| store_ptr | output | 64 | Current store pointer |

## Verification
The bench builds the engine with its default values: a 64-bit pointer, 8-byte words and a 6-bit index. This makes the reserved slot every 64th word, so a full collection wrap can be reached in a few stores by loading the pointer just below a 0x3F index. A vector table alternates the two byte orders and several tag patterns over consecutive slots. Directed cases then cover index masking at a low index and at 0x3E, the bit-63 write, mode-gated access, back-pressure on the store slot, the collection store in big-endian order, and a reset taken while a store is pending.

// File: rtl/rspill_pkg.sv
// Package: shared types for the register spill engine.
// Assumes: the collection register is exactly one memory word wide.
package rspill_pkg;

    // Kind of store currently held in the store slot
    typedef enum logic {
        SRC_REG  = 1'b0,
        SRC_COLL = 1'b1
    } store_src_e;

endpackage

// File: rtl/rspill_ptr.sv
// Module: rspill_ptr
// Holds the backing-store pointer. It advances by one word on every
// accepted store, and software may reload it. It also derives the
// collection bit index and flags the reserved collection slot.
// Assumes: step and sw_wr come from the top. sw_wr wins over step.
module rspill_ptr #(
    parameter int PTR_W      = 64,
    parameter int WORD_BYTES = 8,
    parameter int IDX_W      = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_wr,
    input  logic [PTR_W-1:0] sw_data,
    input  logic             step,
    output logic [PTR_W-1:0] ptr,
    output logic [IDX_W-1:0] idx,
    output logic             at_coll_slot
);
    localparam int OFF_W = $clog2(WORD_BYTES);
    localparam logic [PTR_W-1:0] STEP     = PTR_W'(WORD_BYTES);
    localparam logic [PTR_W-1:0] OFF_MASK = PTR_W'(WORD_BYTES - 1);

    // Pointer register: reset, software reload or one-word advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (sw_wr) begin
            ptr <= sw_data & ~OFF_MASK;
        end else if (step) begin
            ptr <= ptr + STEP;
        end
    end

    // Index field and reserved-slot flag
    always_comb begin
        idx          = ptr[OFF_W +: IDX_W];
        at_coll_slot = &idx;
    end

    // R9
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !sw_wr) |=> (ptr == $past(ptr) + STEP));

endmodule

// File: rtl/rspill_natcoll.sv
// Module: rspill_natcoll
// Collection register for the not-a-thing tags. A spill writes one tag
// at the current index and clears the bits above it. Software access is
// gated by mode; the view is masked above the index and at the top bit.
// Assumes: priority is clear, then legal software write, then spill.
module rspill_natcoll #(
    parameter int IDX_W = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [IDX_W-1:0]      idx,
    input  logic                  mode_zero,
    input  logic                  sw_rd,
    input  logic                  sw_wr,
    input  logic [(2**IDX_W)-1:0] sw_wdata,
    input  logic                  spill_set,
    input  logic                  spill_tag,
    input  logic                  clear,
    output logic [(2**IDX_W)-1:0] rd_data,
    output logic                  illegal,
    output logic [(2**IDX_W)-1:0] view
);
    localparam int COLL_W = 2 ** IDX_W;
    localparam logic [COLL_W-1:0] TOP_BIT = {1'b1, {(COLL_W-1){1'b0}}};

    logic [COLL_W-1:0] coll;
    logic [COLL_W-1:0] upto_mask;
    logic [COLL_W-1:0] below_mask;
    logic [COLL_W-1:0] spill_next;
    logic              legal_wr;
    logic              access;

    // Per-bit masks relative to the current index
    for (genvar b = 0; b < COLL_W; b++) begin : g_mask
        assign upto_mask[b]  = (b != COLL_W - 1) && (IDX_W'(b) <= idx);
        assign below_mask[b] = (IDX_W'(b) < idx);
    end

    // Masked view and next value for a spill
    always_comb begin
        view       = coll & upto_mask;
        spill_next = (coll & below_mask) | (COLL_W'(spill_tag) << idx);
        access     = sw_rd || sw_wr;
        legal_wr   = sw_wr && mode_zero;
    end

    // Collection storage update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coll <= '0;
        end else if (clear) begin
            coll <= '0;
        end else if (legal_wr) begin
            coll <= sw_wdata & ~TOP_BIT;
        end else if (spill_set) begin
            coll <= spill_next;
        end
    end

    // Read port and illegal-access pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            illegal <= 1'b0;
        end else begin
            illegal <= access && !mode_zero;
            if (sw_rd && mode_zero) begin
                rd_data <= view;
            end
        end
    end

    // R6
    gated_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (access && !mode_zero && !clear && !spill_set) |=>
            (illegal && coll == $past(coll)));

    // R10
    coll_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (coll == '0));

endmodule

// File: rtl/rspill_store_slot.sv
// Module: rspill_store_slot
// One-entry registered store port. It applies the selected byte order
// when loaded, and holds address and data until memory accepts them.
// Assumes: load is raised only while the slot is empty.
module rspill_store_slot
    import rspill_pkg::*;
#(
    parameter int PTR_W      = 64,
    parameter int WORD_BYTES = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic [PTR_W-1:0]          load_addr,
    input  logic [8*WORD_BYTES-1:0]   load_data,
    input  logic                      load_big,
    input  store_src_e                load_src,
    input  logic                      mem_ready,
    output logic                      mem_valid,
    output logic [PTR_W-1:0]          mem_addr,
    output logic [8*WORD_BYTES-1:0]   mem_data,
    output store_src_e                held_src,
    output logic                      accept
);
    localparam int DATA_W = 8 * WORD_BYTES;

    logic [DATA_W-1:0] swapped;
    logic [DATA_W-1:0] ordered;

    // Byte reversal network, one lane per byte
    for (genvar k = 0; k < WORD_BYTES; k++) begin : g_swap
        assign swapped[8*k +: 8] = load_data[8*(WORD_BYTES-1-k) +: 8];
    end

    // Byte-order select and handshake completion
    always_comb begin
        ordered = load_big ? swapped : load_data;
        accept  = mem_valid && mem_ready;
    end

    // Slot register: fill on load, empty on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_valid <= 1'b0;
            mem_addr  <= '0;
            mem_data  <= '0;
            held_src  <= SRC_REG;
        end else if (load) begin
            mem_valid <= 1'b1;
            mem_addr  <= load_addr;
            mem_data  <= ordered;
            held_src  <= load_src;
        end else if (accept) begin
            mem_valid <= 1'b0;
        end
    end

    // R9
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=>
            (mem_valid && $stable(mem_addr) && $stable(mem_data)));

    // R2
    no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !mem_valid);

endmodule

// File: rtl/rspill_engine.sv
// Module: rspill_engine (top)
// Register spill engine. It spills tagged registers through a store
// pointer and collects their tags. At the reserved slot it stores the
// collection word, and it gates software access to the collection by mode.
// Assumes: the byte order changes only while the mode is 0; the memory
// is ordinary cacheable storage that accepts any word-aligned address.
module rspill_engine
    import rspill_pkg::*;
#(
    parameter int PTR_W      = 64,
    parameter int WORD_BYTES = 8,
    parameter int IDX_W      = 6,
    parameter int MODE_W     = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ctl_wr,
    input  logic [MODE_W-1:0]       ctl_mode,
    input  logic                    ctl_big,
    input  logic                    ptr_wr,
    input  logic [PTR_W-1:0]        ptr_wdata,
    input  logic                    load_reset,
    input  logic                    spill_valid,
    input  logic [8*WORD_BYTES-1:0] spill_data,
    input  logic                    spill_tag,
    output logic                    spill_ready,
    input  logic                    nat_rd,
    input  logic                    nat_wr,
    input  logic [8*WORD_BYTES-1:0] nat_wdata,
    output logic [8*WORD_BYTES-1:0] nat_rdata,
    output logic                    nat_illegal,
    output logic                    mem_valid,
    input  logic                    mem_ready,
    output logic [PTR_W-1:0]        mem_addr,
    output logic [8*WORD_BYTES-1:0] mem_data,
    output logic [PTR_W-1:0]        store_ptr
);
    localparam int DATA_W = 8 * WORD_BYTES;
    localparam int OFF_W  = $clog2(WORD_BYTES);
    localparam int COLL_W = 2 ** IDX_W;

    logic [MODE_W-1:0] mode;
    logic              big;
    logic              mode_on;
    logic [IDX_W-1:0]  idx;
    logic              at_coll_slot;
    logic              sw_hold;
    logic              issue_coll;
    logic              spill_fire;
    logic              slot_load;
    logic [DATA_W-1:0] slot_data;
    store_src_e        slot_src;
    store_src_e        held_src;
    logic              accept;
    logic              coll_clear;
    logic [COLL_W-1:0] coll_view;

    // Control register: mode field and byte-order bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= '0;
            big  <= 1'b0;
        end else if (ctl_wr) begin
            mode <= ctl_mode;
            big  <= ctl_big;
        end
    end

    // Issue decision for the store slot
    always_comb begin
        mode_on     = |mode;
        sw_hold     = ptr_wr || load_reset;
        issue_coll  = mode_on && !mem_valid && at_coll_slot && !sw_hold;
        spill_ready = mode_on && !mem_valid && !at_coll_slot && !sw_hold;
        spill_fire  = spill_valid && spill_ready;
        slot_load   = spill_fire || issue_coll;
        slot_src    = issue_coll ? SRC_COLL : SRC_REG;
        slot_data   = issue_coll ? DATA_W'(coll_view) : spill_data;
        coll_clear  = sw_hold || (accept && held_src == SRC_COLL);
    end

    rspill_ptr #(
        .PTR_W      (PTR_W),
        .WORD_BYTES (WORD_BYTES),
        .IDX_W      (IDX_W)
    ) u_ptr (
        .clk          (clk),
        .rst_n        (rst_n),
        .sw_wr        (ptr_wr),
        .sw_data      (ptr_wdata),
        .step         (accept),
        .ptr          (store_ptr),
        .idx          (idx),
        .at_coll_slot (at_coll_slot)
    );

    rspill_natcoll #(
        .IDX_W (IDX_W)
    ) u_coll (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx       (idx),
        .mode_zero (!mode_on),
        .sw_rd     (nat_rd),
        .sw_wr     (nat_wr),
        .sw_wdata  (COLL_W'(nat_wdata)),
        .spill_set (spill_fire),
        .spill_tag (spill_tag),
        .clear     (coll_clear),
        .rd_data   (nat_rdata),
        .illegal   (nat_illegal),
        .view      (coll_view)
    );

    rspill_store_slot #(
        .PTR_W      (PTR_W),
        .WORD_BYTES (WORD_BYTES)
    ) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (slot_load),
        .load_addr (store_ptr),
        .load_data (slot_data),
        .load_big  (big),
        .load_src  (slot_src),
        .mem_ready (mem_ready),
        .mem_valid (mem_valid),
        .mem_addr  (mem_addr),
        .mem_data  (mem_data),
        .held_src  (held_src),
        .accept    (accept)
    );

    // R2
    spill_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spill_valid && spill_ready) |=>
            (mem_valid && mem_addr == $past(store_ptr)));

    // R8
    coll_slot_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && held_src == SRC_COLL) |-> (&mem_addr[OFF_W +: IDX_W]));

endmodule

// File: tb/sim_rspill_engine.sv
module sim_rspill_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [1:0]  ctl_mode = '0;
    logic        ctl_big = 1'b0;
    logic        ptr_wr = 1'b0;
    logic [63:0] ptr_wdata = '0;
    logic        load_reset = 1'b0;
    logic        spill_valid = 1'b0;
    logic [63:0] spill_data = '0;
    logic        spill_tag = 1'b0;
    logic        spill_ready;
    logic        nat_rd = 1'b0;
    logic        nat_wr = 1'b0;
    logic [63:0] nat_wdata = '0;
    logic [63:0] nat_rdata;
    logic        nat_illegal;
    logic        mem_valid;
    logic        mem_ready = 1'b1;
    logic [63:0] mem_addr;
    logic [63:0] mem_data;
    logic [63:0] store_ptr;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rspill_engine u0 (.*);

    // {byte-order, tag, data}
    localparam logic [65:0] VEC [8] = '{
        {1'b0, 1'b1, 64'h0123_4567_89AB_CDEF},
        {1'b1, 1'b0, 64'h0123_4567_89AB_CDEF},
        {1'b1, 1'b1, 64'hFF00_0000_0000_00AA},
        {1'b0, 1'b0, 64'h0000_0000_0000_0000},
        {1'b0, 1'b1, 64'hDEAD_BEEF_0BAD_F00D},
        {1'b1, 1'b1, 64'h8000_0000_0000_0001},
        {1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF},
        {1'b1, 1'b1, 64'h1122_3344_5566_7788}
    };

    function automatic logic [63:0] bswap(input logic [63:0] d);
        return {<<8{d}};
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_ctl(input logic [1:0] m, input logic b);
        ctl_wr = 1'b1; ctl_mode = m; ctl_big = b;
        tick();
        ctl_wr = 1'b0;
    endtask

    task automatic set_ptr(input logic [63:0] p);
        ptr_wr = 1'b1; ptr_wdata = p;
        tick();
        ptr_wr = 1'b0;
    endtask

    task automatic nat_write(input logic [63:0] d);
        nat_wr = 1'b1; nat_wdata = d;
        tick();
        nat_wr = 1'b0;
    endtask

    task automatic nat_read_check(input string req, input logic [63:0] exp);
        nat_rd = 1'b1;
        tick();
        nat_rd = 1'b0;
        check(req, nat_rdata, exp);
    endtask

    // Offer a spill, wait for acceptance, check the store, let it retire
    task automatic spill(input logic [63:0] d, input logic t,
                         input logic [63:0] exp_addr, input logic [63:0] exp_data,
                         input string req);
        int guard;
        spill_valid = 1'b1; spill_data = d; spill_tag = t;
        guard = 0;
        while (!spill_ready && guard < 50) begin
            tick();
            guard++;
        end
        tick();
        spill_valid = 1'b0;
        check({req, " valid"}, 64'(mem_valid), 64'd1);
        check({req, " addr"}, mem_addr, exp_addr);
        check({req, " data"}, mem_data, exp_data);
        tick();
    endtask

    initial begin
        logic [63:0] exp_coll;
        logic        cur_big;

        repeat (3) tick();
        // R1: reset state
        check("R1 ptr", store_ptr, 64'd0);
        check("R1 mem_valid", 64'(mem_valid), 64'd0);
        check("R1 spill_ready", 64'(spill_ready), 64'd0);
        check("R1 illegal", 64'(nat_illegal), 64'd0);
        rst_n = 1'b1;
        tick();
        nat_read_check("R1 coll", 64'd0);

        // R5: mask above a low index (idx 5)
        set_ptr(64'h28);
        nat_write('1);
        nat_read_check("R5 mask idx5", 64'h3F);
        // R10: pointer write clears
        set_ptr(64'h1F0);
        nat_read_check("R10 ptr write clear", 64'd0);
        // R4: bit 63 write ignored, idx 0x3E
        nat_write('1);
        nat_read_check("R4 top bit", 64'h7FFF_FFFF_FFFF_FFFF);
        // R10: load-reset clears
        load_reset = 1'b1;
        tick();
        load_reset = 1'b0;
        nat_read_check("R10 load reset clear", 64'd0);

        // R6: access with nonzero mode
        set_ctl(2'd1, 1'b0);
        nat_wr = 1'b1; nat_wdata = 64'h55;
        tick();
        nat_wr = 1'b0;
        check("R6 illegal on write", 64'(nat_illegal), 64'd1);
        tick();
        check("R6 illegal is a pulse", 64'(nat_illegal), 64'd0);
        nat_rd = 1'b1;
        tick();
        nat_rd = 1'b0;
        check("R6 illegal on read", 64'(nat_illegal), 64'd1);
        check("R6 read data not updated", nat_rdata, 64'd0);
        set_ctl(2'd0, 1'b0);
        nat_read_check("R6 collection unchanged", 64'd0);

        // R2 R3 R7 R9: vector table
        set_ptr(64'h1000);
        exp_coll = '0;
        cur_big = 1'b0;
        set_ctl(2'd3, 1'b0);
        for (int i = 0; i < 8; i++) begin
            if (VEC[i][65] != cur_big) begin
                cur_big = VEC[i][65];
                set_ctl(2'd3, cur_big);
            end
            exp_coll[i] = VEC[i][64];
            spill(VEC[i][63:0], VEC[i][64], 64'h1000 + 64'(8 * i),
                  cur_big ? bswap(VEC[i][63:0]) : VEC[i][63:0], "R2 R7 vector");
            check("R9 pointer advance", store_ptr, 64'h1000 + 64'(8 * (i + 1)));
        end
        set_ctl(2'd0, 1'b0);
        nat_read_check("R3 collected tags", exp_coll);

        // R9: back-pressure
        set_ctl(2'd3, 1'b0);
        mem_ready = 1'b0;
        spill_valid = 1'b1; spill_data = 64'hA5A5; spill_tag = 1'b1;
        tick();
        spill_valid = 1'b0;
        repeat (3) tick();
        check("R9 held valid", 64'(mem_valid), 64'd1);
        check("R9 held addr", mem_addr, 64'h1040);
        check("R9 held data", mem_data, 64'hA5A5);
        check("R9 ptr frozen", store_ptr, 64'h1040);
        check("R2 no ready while busy", 64'(spill_ready), 64'd0);
        mem_ready = 1'b1;
        tick();
        check("R9 advance after accept", store_ptr, 64'h1048);

        // R8: collection wrap, big-endian
        set_ctl(2'd0, 1'b1);
        set_ptr(64'h11E8);
        set_ctl(2'd3, 1'b1);
        spill(64'h1, 1'b1, 64'h11E8, bswap(64'h1), "R8 pre-wrap a");
        spill(64'h2, 1'b0, 64'h11F0, bswap(64'h2), "R8 pre-wrap b");
        spill_valid = 1'b1; spill_data = 64'h3; spill_tag = 1'b1;
        check("R8 ready low at reserved slot", 64'(spill_ready), 64'd0);
        tick();
        check("R8 coll store valid", 64'(mem_valid), 64'd1);
        check("R8 coll store addr", mem_addr, 64'h11F8);
        check("R7 R8 coll store data", mem_data, bswap(64'h2000_0000_0000_0000));
        check("R8 spill waits", 64'(spill_ready), 64'd0);
        tick();
        check("R9 ptr after coll store", store_ptr, 64'h1200);
        check("R8 ready after coll store", 64'(spill_ready), 64'd1);
        tick();
        spill_valid = 1'b0;
        check("R8 spill after wrap addr", mem_addr, 64'h1200);
        tick();
        set_ctl(2'd0, 1'b1);
        nat_read_check("R10 cleared by coll store", 64'h1);

        // R1: reset with a store pending
        set_ctl(2'd3, 1'b0);
        mem_ready = 1'b0;
        spill_valid = 1'b1; spill_data = 64'h77; spill_tag = 1'b0;
        tick();
        spill_valid = 1'b0;
        rst_n = 1'b0;
        tick();
        check("R1 reset drops store", 64'(mem_valid), 64'd0);
        check("R1 reset ptr", store_ptr, 64'd0);
        check("R1 reset mode", 64'(spill_ready), 64'd0);
        rst_n = 1'b1;
        mem_ready = 1'b1;
        tick();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule